// File: doc/BRIEF.md
# Configurable Scope Trigger Unit

This block watches a stream of samples, each an unsigned 10-bit analog level with an 8-bit logic-lane byte. From a small bank of 8-bit configuration registers it decides, beat by beat, whether the current sample completes a trigger event. When it does, the block raises a one-cycle pulse. There are four modes:

- a plain crossing of a 10-bit threshold on a chosen edge;
- a crossing that only counts when the excursion's width is below a limit;
- a crossing that only counts when the excursion's width is at or above that limit;
- a masked comparison of the lane byte.

A programmable holdoff blocks retriggering for a number of beats after each pulse.

Samples arrive on a valid/ready interface. The block never applies back-pressure: ready is held high, so every cycle with valid high is an accepted beat. Idle cycles (valid low) do not advance any state: edge history, width counting and holdoff all count beats, not clock cycles. Configuration is written through a plain single-cycle write strobe. A beat accepted in the same cycle as a write is judged with the values held before that write.

Top module: `scope_trig`

## Requirements
- R1: After reset `trig_pulse` is low, `smp_ready` is high and every configuration register is zero, so the trigger is disabled.
- R2: A beat is accepted when `smp_valid` is high. `trig_pulse` is high for exactly the one cycle following the clock edge that accepted an event-producing beat, and is never high after a cycle without a beat.
- R3: The threshold is {control bits 1:0, register 3}. A sample counts as "above" when its level is greater than or equal to the threshold. Writes to addresses other than 3, 4, 5, 6, 7, 8 and 11 change nothing.
- R4: With mode bits 6:5 of control register 4 at 00, an event occurs on a crossing. Bit 2 at 0 selects below-to-above; bit 2 at 1 selects above-to-below. The first beat after reset never forms a crossing.
- R5: Width is the number of beats from the qualifying crossing to the next opposite crossing. In mode 01 the event occurs on that opposite crossing if the width is below register 11.
- R6: In mode 10 the event occurs on the opposite crossing if the width is at or above register 11. The width saturates at 255.
- R7: In mode 11 an event occurs on every beat where ((lanes XOR register 5) AND NOT register 6) is zero. A 1 in register 6 masks a lane out.
- R8: Control bit 7 must be 1 for any pulse.
- R9: Control bits 4:3 select the output source. Only 00 (trigger pulse) drives `trig_pulse`; any other value keeps it low.
- R10: After a pulse-producing beat, the next H accepted beats cannot produce a pulse, where H is {register 8, register 7} taken at that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| smp_valid | input | 1 | Sample beat valid |
| smp_ready | output | 1 | Sample ready, always high |
| smp_level | input | 10 | Analog sample level |
| smp_lanes | input | 8 | Logic-lane byte of the sample |
| trig_pulse | output | 1 | One-cycle trigger pulse |

## Verification
Every result of this block is due one cycle after the edge that accepts the beat causing it: the pulse comes from a single register fed by that beat. A configuration write affects beats accepted from the following edge onward. Inputs are driven on the falling edge and `trig_pulse` is sampled on the falling edge after each rising edge. That sample is compared, cycle by cycle, with a behavioural model that applies the same one-beat delay. Pulse totals per scenario are read only after two idle cycles, so the last possible pulse has already appeared.

// File: rtl/scope_trig_pkg.sv
package scope_trig_pkg;

  typedef enum logic [1:0] {
    MODE_LEVEL  = 2'b00,
    MODE_NARROW = 2'b01,
    MODE_WIDE   = 2'b10,
    MODE_LANES  = 2'b11
  } trig_mode_e;

  // control register layout (bit positions are decoded by the trigger logic)
  typedef struct packed {
    logic       en;       // 7
    trig_mode_e mode;     // 6:5
    logic [1:0] src;      // 4:3
    logic       falling;  // 2
    logic [1:0] thr_hi;   // 1:0
  } ctrl_t;

  localparam logic [3:0] A_THR_LO  = 4'd3;
  localparam logic [3:0] A_CTRL    = 4'd4;
  localparam logic [3:0] A_LMATCH  = 4'd5;
  localparam logic [3:0] A_LMASK   = 4'd6;
  localparam logic [3:0] A_HOLD_LO = 4'd7;
  localparam logic [3:0] A_HOLD_HI = 4'd8;
  localparam logic [3:0] A_WLIM    = 4'd11;

  localparam logic [1:0] SRC_PULSE = 2'b00;

endpackage

// File: rtl/scope_trig_regs.sv
module scope_trig_regs
  import scope_trig_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 4,
  localparam int HOLD_W = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  thr_lo,
  output ctrl_t             ctrl,
  output logic [REG_W-1:0]  lmatch,
  output logic [REG_W-1:0]  lmask,
  output logic [HOLD_W-1:0] hold,
  output logic [REG_W-1:0]  wlim
);

  logic [REG_W-1:0] hold_lo, hold_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_lo  <= '0;
      ctrl    <= '0;
      lmatch  <= '0;
      lmask   <= '0;
      hold_lo <= '0;
      hold_hi <= '0;
      wlim    <= '0;
    end else if (wr) begin
      case (addr)
        A_THR_LO:  thr_lo  <= wdata;
        A_CTRL:    ctrl    <= ctrl_t'(wdata);
        A_LMATCH:  lmatch  <= wdata;
        A_LMASK:   lmask   <= wdata;
        A_HOLD_LO: hold_lo <= wdata;
        A_HOLD_HI: hold_hi <= wdata;
        A_WLIM:    wlim    <= wdata;
        default:   ;
      endcase
    end
  end

  assign hold = {hold_hi, hold_lo};

endmodule

// File: rtl/scope_trig_level.sv
module scope_trig_level
  import scope_trig_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int WIDTH_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat,
  input  logic [SAMPLE_W-1:0] level,
  input  logic [SAMPLE_W-1:0] thresh,
  input  logic                falling,
  input  trig_mode_e          mode,
  input  logic [WIDTH_W-1:0]  wlim,
  output logic                fire
);

  logic               prev_above, primed, measuring;
  logic [WIDTH_W-1:0] width_q, width_n;
  logic               above, up_x, down_x, qual_x, opp_x;

  assign above  = level >= thresh;
  assign up_x   = primed && !prev_above && above;
  assign down_x = primed && prev_above && !above;
  assign qual_x = falling ? down_x : up_x;
  assign opp_x  = falling ? up_x : down_x;
  assign width_n = (width_q == '1) ? width_q : width_q + 1'b1;

  always_comb begin
    unique case (mode)
      MODE_LEVEL:  fire = qual_x;
      MODE_NARROW: fire = measuring && opp_x && (width_n < wlim);
      MODE_WIDE:   fire = measuring && opp_x && (width_n >= wlim);
      default:     fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_above <= 1'b0;
      primed     <= 1'b0;
      measuring  <= 1'b0;
      width_q    <= '0;
    end else if (beat) begin
      prev_above <= above;
      primed     <= 1'b1;
      if (qual_x) begin
        measuring <= 1'b1;
        width_q   <= '0;
      end else if (measuring) begin
        if (opp_x) measuring <= 1'b0;
        else       width_q   <= width_n;
      end
    end
  end

endmodule

// File: rtl/scope_trig_lanes.sv
module scope_trig_lanes #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] lanes,
  input  logic [LANE_W-1:0] match,
  input  logic [LANE_W-1:0] ignore,
  output logic              hit
);

  logic [LANE_W-1:0] miss;

  for (genvar i = 0; i < LANE_W; i++) begin : g_lane
    assign miss[i] = !ignore[i] && (lanes[i] != match[i]);
  end

  assign hit = (miss == '0);

endmodule

// File: rtl/scope_trig_holdoff.sv
module scope_trig_holdoff #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              event_in,
  input  logic [HOLD_W-1:0] hold_val,
  output logic              pulse,
  output logic              busy
);

  logic [HOLD_W-1:0] hold_cnt;

  assign busy = (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      pulse    <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (beat) begin
        if (busy) begin
          hold_cnt <= hold_cnt - 1'b1;
        end else if (event_in) begin
          pulse    <= 1'b1;
          hold_cnt <= hold_val;
        end
      end
    end
  end

endmodule

// File: rtl/scope_trig.sv
module scope_trig
  import scope_trig_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int LANE_W   = 8,
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_level,
  input  logic [LANE_W-1:0]   smp_lanes,
  output logic                trig_pulse
);

  localparam int HOLD_W = 2 * REG_W;

  logic [REG_W-1:0]    thr_lo, lmatch, lmask, wlim;
  logic [HOLD_W-1:0]   hold_val;
  ctrl_t               ctrl;
  logic [SAMPLE_W-1:0] thresh;
  logic                beat, level_fire, lane_hit, trig_event, hold_busy;

  assign smp_ready = 1'b1;
  assign beat      = smp_valid && smp_ready;
  assign thresh    = {ctrl.thr_hi, thr_lo};

  scope_trig_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .thr_lo(thr_lo), .ctrl(ctrl), .lmatch(lmatch), .lmask(lmask),
    .hold(hold_val), .wlim(wlim)
  );

  scope_trig_level #(.SAMPLE_W(SAMPLE_W), .WIDTH_W(REG_W)) u_level (
    .clk(clk), .rst_n(rst_n), .beat(beat), .level(smp_level), .thresh(thresh),
    .falling(ctrl.falling), .mode(ctrl.mode), .wlim(wlim), .fire(level_fire)
  );

  scope_trig_lanes #(.LANE_W(LANE_W)) u_lanes (
    .lanes(smp_lanes), .match(lmatch[LANE_W-1:0]), .ignore(lmask[LANE_W-1:0]),
    .hit(lane_hit)
  );

  assign trig_event = ctrl.en && (ctrl.src == SRC_PULSE) &&
                      ((ctrl.mode == MODE_LANES) ? lane_hit : level_fire);

  scope_trig_holdoff #(.HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .beat(beat), .event_in(trig_event),
    .hold_val(hold_val), .pulse(trig_pulse), .busy(hold_busy)
  );

endmodule

// File: rtl/scope_trig_chk.sv
module scope_trig_chk #(
  parameter int LANE_W = 8,
  parameter int HOLD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              trig_pulse,
  input logic [7:0]        ctrl_bits,
  input logic [HOLD_W-1:0] hold_val,
  input logic [LANE_W-1:0] lanes,
  input logic [LANE_W-1:0] match,
  input logic [LANE_W-1:0] ignore
);

  p_pulse_needs_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(smp_valid));

  p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(ctrl_bits[7]));

  p_source_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> ($past(ctrl_bits[4:3]) == 2'b00));

  p_lane_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && ($past(ctrl_bits[6:5]) == 2'b11)) |->
      ($past((lanes ^ match) & ~ignore) == '0));

  p_holdoff_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && ($past(hold_val) != '0)) |=> !trig_pulse);

endmodule

bind scope_trig scope_trig_chk #(.LANE_W(LANE_W), .HOLD_W(2 * REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .trig_pulse(trig_pulse),
  .ctrl_bits(ctrl), .hold_val(hold_val), .lanes(smp_lanes),
  .match(lmatch[LANE_W-1:0]), .ignore(lmask[LANE_W-1:0])
);

// File: tb/scope_trig_tb.sv
module scope_trig_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [9:0] smp_level = '0;
  logic [7:0] smp_lanes = '0;
  logic       trig_pulse;

  always #5 clk = ~clk;

  scope_trig u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_level(smp_level), .smp_lanes(smp_lanes), .trig_pulse(trig_pulse)
  );

  int    n_tests = 0, n_fail = 0, pulses = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_reg [16];
  int m_prev, m_primed, m_meas, m_cnt, m_hold, m_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_prev = 0; m_primed = 0; m_meas = 0; m_cnt = 0; m_hold = 0; m_exp = 0;
    end else begin
      m_exp = 0;
      if (smp_valid) begin
        int thr, above, up, dn, qual, opp, ev, mode, w;
        thr   = (m_reg[4] % 4) * 256 + m_reg[3];
        above = (int'(smp_level) >= thr);
        up    = m_primed && !m_prev && above;
        dn    = m_primed && m_prev && !above;
        qual  = (m_reg[4] & 4) ? dn : up;
        opp   = (m_reg[4] & 4) ? up : dn;
        mode  = (m_reg[4] / 32) % 4;
        w     = (m_cnt + 1 > 255) ? 255 : m_cnt + 1;
        ev    = 0;
        if (mode == 3) ev = (((int'(smp_lanes) ^ m_reg[5]) & ~m_reg[6] & 255) == 0);
        else if (mode == 0) ev = qual;
        else if (m_meas && opp) ev = (mode == 1) ? (w < m_reg[11]) : (w >= m_reg[11]);
        if (qual) begin m_meas = 1; m_cnt = 0; end
        else if (m_meas) begin
          if (opp) m_meas = 0; else m_cnt = w;
        end
        m_prev = above; m_primed = 1;
        ev = ev && (m_reg[4] >= 128) && (((m_reg[4] / 8) % 4) == 0);
        if (m_hold > 0) m_hold = m_hold - 1;
        else if (ev) begin m_exp = 1; m_hold = m_reg[8] * 256 + m_reg[7]; end
      end
      if (cfg_wr) m_reg[cfg_addr] = int'(cfg_wdata);
    end
  end

  function automatic void chk(string req, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, int'(trig_pulse), m_exp);
      if (trig_pulse) pulses++;
    end
  end

  task automatic wr(input int a, input int d);
    cfg_wr = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic beat(input int lvl, input int ln);
    smp_valid = 1'b1; smp_level = 10'(lvl); smp_lanes = 8'(ln);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start(input string req);
    idle(2);
    cur_req = req;
    pulses = 0;
  endtask

  task automatic total(input string req, input int exp);
    idle(2);
    chk(req, pulses, exp);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(trig_pulse), 0);
    chk("R1", int'(smp_ready), 1);

    // R8: all-zero config after reset -> disabled
    start("R8");
    for (int i = 0; i < 3; i++) beat(10'h300, 0);
    total("R8", 0);

    // R3/R4 rising, threshold 0x180 boundary
    start("R4");
    wr(3, 8'h80); wr(4, 8'h81);
    beat(10'h100, 0); beat(10'h17F, 0); beat(10'h180, 0);
    beat(10'h200, 0); beat(10'h100, 0); beat(10'h300, 0);
    total("R3", 2);

    // R4 falling
    start("R4");
    wr(4, 8'h85);
    beat(10'h200, 0); beat(10'h17F, 0); beat(10'h100, 0);
    beat(10'h180, 0); beat(10'h000, 0);
    total("R4", 2);

    // R5 width below limit 3
    start("R5");
    wr(11, 3); wr(4, 8'hA1);
    beat(10'h200, 0); beat(10'h200, 0); beat(10'h000, 0);
    beat(10'h200, 0); beat(10'h200, 0); beat(10'h200, 0); beat(10'h000, 0);
    total("R5", 1);

    // R6 width at or above limit 3, including a saturated run
    start("R6");
    wr(4, 8'hC1);
    beat(10'h200, 0); beat(10'h200, 0); beat(10'h000, 0);
    beat(10'h200, 0); beat(10'h200, 0); beat(10'h200, 0); beat(10'h000, 0);
    for (int i = 0; i < 301; i++) beat(10'h200, 0);
    beat(10'h000, 0);
    total("R6", 2);

    // R6 limit 255 reached only through saturation
    start("R6");
    wr(11, 255);
    for (int i = 0; i < 300; i++) beat(10'h200, 0);
    beat(10'h000, 0);
    total("R6", 1);

    // R7 masked lane match
    start("R7");
    wr(5, 8'hA5); wr(6, 8'h0F); wr(4, 8'hE0);
    beat(0, 8'hA0); beat(0, 8'hAF); beat(0, 8'hB5); beat(0, 8'h5A); beat(0, 8'hA5);
    total("R7", 3);

    // R3 writes to unused addresses change nothing
    start("R3");
    wr(6, 8'hFF);
    wr(0, 8'hFF); wr(9, 8'hFF); wr(15, 8'hFF); wr(12, 8'hFF);
    for (int i = 0; i < 5; i++) beat(0, i);
    total("R3", 5);

    // R10 holdoff 3, with idle gaps (R2)
    start("R10");
    wr(7, 3);
    for (int i = 0; i < 6; i++) beat(0, 0);
    idle(2);
    for (int i = 0; i < 6; i++) beat(0, 0);
    total("R10", 3);

    // R10 holdoff 256 via high byte
    start("R10");
    wr(7, 0); wr(8, 1);
    for (int i = 0; i < 300; i++) beat(0, 0);
    total("R10", 2);

    // R9 non-pulse output sources
    start("R9");
    wr(8, 0); wr(4, 8'hE8);
    for (int i = 0; i < 250; i++) beat(0, 0);
    wr(4, 8'hF8);
    for (int i = 0; i < 5; i++) beat(0, 0);
    total("R9", 0);

    // R8 enable bit cleared
    start("R8");
    wr(4, 8'h60);
    for (int i = 0; i < 5; i++) beat(0, 0);
    total("R8", 0);

    // R2 pulse returns to low after one cycle
    start("R2");
    wr(4, 8'hE0);
    beat(0, 0);
    chk("R2", int'(trig_pulse), 1);
    @(negedge clk);
    chk("R2", int'(trig_pulse), 0);
    total("R2", 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule